// File: doc/BRIEF.md
# Even/Odd Multi-Driver Load Scheduler

This block feeds a group of six-channel column drivers from one pixel stream so that together they cover 12 columns (two drivers) or 24 columns (four drivers) per color. Each pixel is presented for one pixel clock on a shared data bus. The block produces a driver clock at half the pixel rate. Even-numbered words are captured by drivers that sample on the rising edge of that clock, and odd-numbered words by drivers that sample on the falling edge.

Each even/odd pair of drivers covers twelve consecutive words of a group. Every driver has its own start strobe, and the strobes of successive pairs are spaced six driver-clock cycles apart. A single transfer strobe follows each completed group and updates every driver at once, so the next group loads while the previous one is shown. A line-start pulse realigns the word count to zero and samples the load direction for the line. Two target outputs report which driver and channel the word now on the bus lands in, for the sampled direction.

Timing contract: a pixel on `pix_i` is registered at the rising pixel-clock edge and held on `data_o` for the next pixel cycle. `drv_clk_o` changes at the same edges, so a driver rising edge ends an even word and a falling edge ends an odd word.

Top module: `eo_load_sched`

## Requirements
- R1: After reset and until the first line start, `data_o`, `drv_clk_o`, `start_o`, `xfer_o`, `tgt_drv_o` and `tgt_ch_o` are all zero, whatever `pix_i` carries.
- R2: From the cycle after a line start, `data_o` equals `pix_i` of the previous pixel clock. Word index 0 is the pixel presented together with `line_start_i`.
- R3: `drv_clk_o` is 0 while an even word index is on `data_o` and 1 while an odd one is, so it toggles every pixel clock during a line.
- R4: `start_o[2p]` and `start_o[2p+1]` are high exactly while group word indices 12p and 12p+1 are on `data_o`, for pair p. Successive pairs are 12 pixel clocks (6 driver-clock cycles) apart.
- R5: `xfer_o` is high while word indices 0 and 1 of a group are on `data_o`, but only when a complete group was loaded earlier in the same line. It is never high during the first group of a line.
- R6: `tgt_drv_o` = 2*(w/12) + (w mod 2) for group word index w, with drivers numbered from 0.
- R7: With the direction sampled as 0, `tgt_ch_o` = (w mod 12)/2. With it sampled as 1, `tgt_ch_o` = 5 - (w mod 12)/2. For example, word 10 lands on channel 0 of the even driver and word 11 on channel 0 of the odd driver.
- R8: `dir_i` is sampled only in the cycle of a line start. A change during a line has no effect on `tgt_ch_o` until the next line start.
- R9: A line start in the middle of a group restarts at word index 0 and drops the partial group. No transfer strobe follows it.
- R10: The parameter `NUM_DRV` (2 or 4) sets the group size to 6*`NUM_DRV` words. The word index wraps from 6*`NUM_DRV`-1 to 0 and keeps running until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Line-start pulse, coincident with pixel 0 |
| dir_i | input | 1 | Load direction (0 ascending, 1 descending), sampled at line start |
| pix_i | input | DATA_W | Pixel word |
| drv_clk_o | output | 1 | Half-rate driver clock |
| start_o | output | NUM_DRV | Per-driver start strobes (even index = rising-edge driver) |
| xfer_o | output | 1 | Shared transfer strobe |
| data_o | output | DATA_W | Data bus to all drivers |
| tgt_drv_o | output | $clog2(NUM_DRV) | Driver receiving the word on `data_o` |
| tgt_ch_o | output | 3 | Channel receiving the word on `data_o` |

## Verification
The bench runs an ascending line across more than four 24-word groups with a counting-plus-offset pixel pattern. This separates the one-cycle data delay, the driver-clock phase, and the staggered start strobes of the two pairs, and shows that the transfer strobe is absent in the first group and present after each wrap. A descending line with `dir_i` flipped midway tells the reversed channel order apart from a direction that leaks in mid-line. A line restarted at word 17 shows that the partial group is discarded rather than transferred. Pixels pushed before any line start confirm the idle outputs.

// File: rtl/eo_pkg.sv
package eo_pkg;
  localparam int unsigned CH_PER_DRV = 6;

  typedef enum logic {
    DIR_ASC  = 1'b0,
    DIR_DESC = 1'b1
  } load_dir_e;
endpackage

// File: rtl/eo_word_cnt.sv
module eo_word_cnt #(
  parameter int unsigned GRP_WORDS = 24,
  parameter int unsigned WW        = $clog2(GRP_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_start_i,
  output logic [WW-1:0] widx_o,
  output logic          active_o,
  output logic          wrapped_o
);
  localparam logic [WW-1:0] LastIdx = WW'(GRP_WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_o    <= '0;
      active_o  <= 1'b0;
      wrapped_o <= 1'b0;
    end else if (line_start_i) begin
      widx_o    <= '0;
      active_o  <= 1'b1;
      wrapped_o <= 1'b0;
    end else if (active_o) begin
      if (widx_o == LastIdx) begin
        widx_o    <= '0;
        wrapped_o <= 1'b1;
      end else begin
        widx_o <= widx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eo_strobe_gen.sv
module eo_strobe_gen #(
  parameter int unsigned NUM_DRV = 4,
  parameter int unsigned WPP     = 12,
  parameter int unsigned WW      = 5
) (
  input  logic [WW-1:0]      widx_i,
  input  logic               active_i,
  input  logic               wrapped_i,
  output logic               drv_clk_o,
  output logic [NUM_DRV-1:0] start_o,
  output logic               xfer_o
);
  localparam int unsigned NumPair = NUM_DRV / 2;

  // driver clock high while odd word on bus
  assign drv_clk_o = active_i & widx_i[0];
  // one driver cycle after a finished group
  assign xfer_o    = active_i & wrapped_i & (widx_i < WW'(2));

  for (genvar p = 0; p < NumPair; p++) begin : g_pair
    logic hit;
    assign hit = active_i &&
                 ((widx_i == WW'(p * WPP)) || (widx_i == WW'(p * WPP + 1)));
    assign start_o[2*p]   = hit;
    assign start_o[2*p+1] = hit;
  end
endmodule

// File: rtl/eo_chan_map.sv
module eo_chan_map
  import eo_pkg::*;
#(
  parameter int unsigned NUM_DRV = 4,
  parameter int unsigned WW      = 5,
  parameter int unsigned DRV_W   = 2,
  parameter int unsigned CH_W    = 3
) (
  input  logic [WW-1:0]    widx_i,
  input  load_dir_e        dir_i,
  output logic [DRV_W-1:0] tgt_drv_o,
  output logic [CH_W-1:0]  tgt_ch_o
);
  localparam int unsigned WPP = 2 * CH_PER_DRV;

  logic [WW-1:0] pair_w, loc_w, half_w;

  assign pair_w = widx_i / WW'(WPP);
  assign loc_w  = widx_i % WW'(WPP);
  assign half_w = loc_w >> 1;

  assign tgt_drv_o = DRV_W'({pair_w, loc_w[0]});
  assign tgt_ch_o  = (dir_i == DIR_DESC) ? CH_W'(CH_PER_DRV - 1) - CH_W'(half_w)
                                         : CH_W'(half_w);
endmodule

// File: rtl/eo_load_sched.sv
module eo_load_sched
  import eo_pkg::*;
#(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned NUM_DRV = 4,
  localparam int unsigned DRV_W  = $clog2(NUM_DRV),
  localparam int unsigned CH_W   = $clog2(CH_PER_DRV)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_start_i,
  input  logic               dir_i,
  input  logic [DATA_W-1:0]  pix_i,
  output logic               drv_clk_o,
  output logic [NUM_DRV-1:0] start_o,
  output logic               xfer_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [DRV_W-1:0]   tgt_drv_o,
  output logic [CH_W-1:0]    tgt_ch_o
);
  localparam int unsigned WPP       = 2 * CH_PER_DRV;
  localparam int unsigned GRP_WORDS = NUM_DRV * CH_PER_DRV;
  localparam int unsigned WW        = $clog2(GRP_WORDS);

  if (NUM_DRV != 2 && NUM_DRV != 4) begin : g_bad_cfg
    $error("NUM_DRV must be 2 or 4");
  end

  logic [WW-1:0] widx_w;
  logic          active_w;
  logic          wrapped_w;
  load_dir_e     dir_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= DIR_ASC;
    end else begin
      if (line_start_i || active_w) data_q <= pix_i;
      if (line_start_i)             dir_q  <= load_dir_e'(dir_i);
    end
  end

  assign data_o = data_q;

  eo_word_cnt #(
    .GRP_WORDS (GRP_WORDS),
    .WW        (WW)
  ) i_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .widx_o       (widx_w),
    .active_o     (active_w),
    .wrapped_o    (wrapped_w)
  );

  eo_strobe_gen #(
    .NUM_DRV (NUM_DRV),
    .WPP     (WPP),
    .WW      (WW)
  ) i_strobe (
    .widx_i    (widx_w),
    .active_i  (active_w),
    .wrapped_i (wrapped_w),
    .drv_clk_o (drv_clk_o),
    .start_o   (start_o),
    .xfer_o    (xfer_o)
  );

  eo_chan_map #(
    .NUM_DRV (NUM_DRV),
    .WW      (WW),
    .DRV_W   (DRV_W),
    .CH_W    (CH_W)
  ) i_map (
    .widx_i    (widx_w),
    .dir_i     (dir_q),
    .tgt_drv_o (tgt_drv_o),
    .tgt_ch_o  (tgt_ch_o)
  );
endmodule

// File: rtl/eo_load_sched_chk.sv
module eo_load_sched_chk #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned NUM_DRV = 4,
  parameter int unsigned CH_W    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               line_start_i,
  input logic [DATA_W-1:0]  pix_i,
  input logic               active_i,
  input logic               drv_clk_o,
  input logic [NUM_DRV-1:0] start_o,
  input logic               xfer_o,
  input logic [DATA_W-1:0]  data_o,
  input logic [CH_W-1:0]    tgt_ch_o
);
  assert_data_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i || active_i) |=> (data_o == $past(pix_i)));

  assert_half_rate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !line_start_i) |=> (drv_clk_o != $past(drv_clk_o)));

  assert_start_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(start_o) == 0) || ($countones(start_o) == 2));

  assert_xfer_with_first_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> start_o[0]);

  assert_ch_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_ch_o < CH_W'(6));

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (!xfer_o && !drv_clk_o && start_o[0]));
endmodule

bind eo_load_sched eo_load_sched_chk #(
  .DATA_W  (DATA_W),
  .NUM_DRV (NUM_DRV),
  .CH_W    (CH_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_start_i (line_start_i),
  .pix_i        (pix_i),
  .active_i     (active_w),
  .drv_clk_o    (drv_clk_o),
  .start_o      (start_o),
  .xfer_o       (xfer_o),
  .data_o       (data_o),
  .tgt_ch_o     (tgt_ch_o)
);

// File: tb/test_eo_load_sched.sv
module test_eo_load_sched;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 10;
  localparam int NUM_DRV    = 4;
  localparam int GRP        = NUM_DRV * 6;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               line_start = 1'b0;
  logic               dir = 1'b0;
  logic [DATA_W-1:0]  pix = '0;
  logic               drv_clk;
  logic [NUM_DRV-1:0] start;
  logic               xfer;
  logic [DATA_W-1:0]  data;
  logic [1:0]         tgt_drv;
  logic [2:0]         tgt_ch;

  int n_chk  = 0;
  int n_fail = 0;

  // requirement model
  int m_w = 0;
  bit m_act = 0;
  bit m_done = 0;
  bit m_dir = 0;
  int m_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eo_load_sched #(.DATA_W(DATA_W), .NUM_DRV(NUM_DRV)) i_eo_load_sched (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_start_i (line_start),
    .dir_i        (dir),
    .pix_i        (pix),
    .drv_clk_o    (drv_clk),
    .start_o      (start),
    .xfer_o       (xfer),
    .data_o       (data),
    .tgt_drv_o    (tgt_drv),
    .tgt_ch_o     (tgt_ch)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic push(input bit ls, input int px, input bit d);
    @(negedge clk);
    line_start = ls;
    pix = DATA_W'(px);
    dir = d;
    @(posedge clk);
    #1;
    if (ls) begin
      m_w = 0; m_act = 1; m_done = 0; m_dir = d;
    end else if (m_act) begin
      if (m_w == GRP - 1) begin m_w = 0; m_done = 1; end
      else m_w++;
    end
    if (ls || m_act) m_data = px % (1 << DATA_W);
  endtask

  task automatic check_all();
    int exp_start;
    int loc;
    loc = m_w % 12;
    exp_start = 0;
    for (int p = 0; p < NUM_DRV/2; p++)
      if (m_act && (m_w / 12) == p && loc < 2) exp_start |= (3 << (2*p));
    chk("R2 data_o", int'(data), m_data);
    chk("R3 drv_clk_o", int'(drv_clk), (m_act && (m_w % 2 == 1)) ? 1 : 0);
    chk("R4 start_o", int'(start), exp_start);
    chk("R5 xfer_o", int'(xfer), (m_act && m_done && m_w < 2) ? 1 : 0);
    chk("R6 tgt_drv_o", int'(tgt_drv), 2 * (m_w / 12) + (m_w % 2));
    chk("R7 tgt_ch_o", int'(tgt_ch), m_dir ? 5 - loc / 2 : loc / 2);
  endtask

  task automatic t_idle_r1();
    chk("R1 reset data_o", int'(data), 0);
    chk("R1 reset start_o", int'(start), 0);
    for (int k = 0; k < 5; k++) begin
      push(0, 100 + k, 1);
      chk("R1 idle data_o", int'(data), 0);
      chk("R1 idle drv_clk_o", int'(drv_clk), 0);
      chk("R1 idle start_o", int'(start), 0);
      chk("R1 idle xfer_o", int'(xfer), 0);
      chk("R1 idle tgt", int'({tgt_drv, tgt_ch}), 0);
    end
  endtask

  task automatic t_ascend_r10();
    for (int k = 0; k < 4 * GRP + 7; k++) begin
      push(k == 0, k * 37 + 5, 0);
      check_all();
      if (k == GRP) begin
        chk("R10 wrap index", int'(tgt_drv), 0);
        chk("R10 wrap xfer", int'(xfer), 1);
      end
      if (k == 12) chk("R4 second pair start", int'(start), 4'b1100);
    end
  endtask

  task automatic t_descend_r8();
    for (int k = 0; k < 2 * GRP + 3; k++) begin
      push(k == 0, 1023 - k * 11, (k < 9) ? 1'b1 : 1'b0);
      check_all();
      if (k == 10) chk("R8 dir held", int'(tgt_ch), 0);
      if (k == 11) chk("R7 word 11 ch", int'(tgt_ch), 0);
    end
  endtask

  task automatic t_restart_r9();
    for (int k = 0; k < 18; k++) begin
      push(k == 0, k + 500, 0);
      check_all();
    end
    for (int k = 0; k < GRP + 4; k++) begin
      push(k == 0, k * 3 + 1, 0);
      check_all();
      if (k < 2)   chk("R9 no xfer after restart", int'(xfer), 0);
      if (k == 0)  chk("R9 restart drv_clk", int'(drv_clk), 0);
      if (k == GRP) chk("R9 xfer after full group", int'(xfer), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_idle_r1();
    t_ascend_r10();
    t_descend_r8();
    t_restart_r9();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule